// File: doc/BRIEF.md
# Serial Shift Data Path

This block is the data half of a general-purpose serial port. An 8-bit data register can be loaded in parallel from a bus and shifts one place to the left on each shift strobe, taking the serial input bit into bit 0. A two-bit source select chooses what produces the strobe:

- a software strobe input,
- a timer compare-match pulse, or
- an edge of an external serial clock.

The external serial clock passes through a two-flop synchroniser, and the selected edge is then detected in the system clock domain.

A 4-bit transfer counter advances once per strobe. When it wraps from all ones to zero, the transfer is complete. At that point the new register contents are copied into a read-only buffer, and a sticky overflow flag is set. The flag can raise an interrupt. If software presets the counter to all ones, a single strobe sets the flag. This lets the external clock pin act as an extra edge-triggered interrupt.

The most significant bit drives the serial output through a holding stage. For internal sources the stage is always open. For external clocking, it is open only while the synchronised clock sits at the level that comes before the shifting edge. As a result, output changes and input sampling fall on opposite serial clock edges.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset, data_q, buf_q and cnt_q are zero, and ovf_flag, irq and ser_dout are low.
- R2: A high wr_data_en loads wr_data into data_q at the next clock edge.
- R3: On a strobe from the selected source, data_q becomes {data_q[6:0], ser_din}. Strobes from sources that are not selected have no effect on data_q or cnt_q.
- R4: When wr_data_en and a strobe fall in the same cycle, data_q takes wr_data and no shift occurs. The counter still advances.
- R5: The src_sel encoding is 0 = sw_strobe, 1 = timer_match, 2 = rising edge of ser_clk_in, 3 = falling edge of ser_clk_in. An external edge shifts the register at the third system clock edge after ser_clk_in changes.
- R6: cnt_q increments by one on each strobe. A high cnt_wr_en loads cnt_wr_data instead, and this load wins over a strobe in the same cycle.
- R7: A strobe with cnt_q at 15 and no counter load sets cnt_q to 0 and sets ovf_flag. The flag stays set until ovf_clr is high. A set in the same cycle wins over the clear.
- R8: When ovf_flag is set by a wrap, buf_q is loaded with the value data_q takes in that same cycle. Otherwise buf_q holds its value.
- R9: irq is high exactly when ovf_flag and ovf_ie are both high.
- R10: With src_sel 0 or 1, ser_dout equals data_q[7] in every cycle.
- R11: With src_sel 2 or 3, ser_dout follows data_q[7] while the synchronised serial clock is low (for mode 2) or high (for mode 3). Otherwise ser_dout holds the last bit passed.
- R12: After cnt_q is preset to 15, one strobe sets ovf_flag, so a single external edge can raise irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 2 | Strobe source select |
| sw_strobe | input | 1 | Software shift strobe, one cycle |
| timer_match | input | 1 | Timer compare-match pulse |
| ser_clk_in | input | 1 | External serial clock, asynchronous |
| ser_din | input | 1 | Serial data input |
| wr_data_en | input | 1 | Parallel write enable for the data register |
| wr_data | input | 8 | Parallel write value |
| cnt_wr_en | input | 1 | Counter load enable |
| cnt_wr_data | input | 4 | Counter load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| data_q | output | 8 | Data register |
| buf_q | output | 8 | Buffer copy taken at transfer end |
| cnt_q | output | 4 | Transfer counter |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |
| ser_dout | output | 1 | Serial data output |

## Verification
A register that shifts wrongly, or that ignores write priority, shows up on data_q one clock after the faulty strobe. It reaches ser_dout once the bad bit travels to the top. A miscounting counter appears on cnt_q at once, but it only shows on buf_q and irq at the next wrap, up to sixteen strobes later. That is why counter presets near 15 are exercised. A synchroniser or holding stage that is off by one cycle shows only on ser_dout and on the timing of external shifts. The reference model therefore compares every output on every clock, across both external edge polarities.

// File: rtl/serial_shift_unit.sv
module serial_shift_unit #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        src_sel,
  input  logic              sw_strobe,
  input  logic              timer_match,
  input  logic              ser_clk_in,
  input  logic              ser_din,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cnt_wr_en,
  input  logic [CNT_W-1:0]  cnt_wr_data,
  input  logic              ovf_clr,
  input  logic              ovf_ie,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] buf_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              ovf_flag,
  output logic              irq,
  output logic              ser_dout
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [2:0]        sck_q;
  logic              strobe, wrap, latch_open, hold_q;
  logic [DATA_W-1:0] data_nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_q <= '0;
    else        sck_q <= {sck_q[1:0], ser_clk_in};

  always_comb begin
    unique case (src_sel)
      2'd0:    strobe = sw_strobe;
      2'd1:    strobe = timer_match;
      2'd2:    strobe = sck_q[1] & ~sck_q[2];
      default: strobe = ~sck_q[1] & sck_q[2];
    endcase
  end

  assign data_nxt   = wr_data_en ? wr_data :
                      strobe     ? {data_q[DATA_W-2:0], ser_din} : data_q;
  assign wrap       = strobe & ~cnt_wr_en & (cnt_q == CNT_MAX);
  assign latch_open = ~src_sel[1] | (sck_q[1] == src_sel[0]);
  assign ser_dout   = latch_open ? data_q[DATA_W-1] : hold_q;
  assign irq        = ovf_flag & ovf_ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      data_q   <= '0;
      buf_q    <= '0;
      cnt_q    <= '0;
      ovf_flag <= 1'b0;
      hold_q   <= 1'b0;
    end else begin
      data_q <= data_nxt;
      if (latch_open) hold_q <= data_q[DATA_W-1];
      if (cnt_wr_en)   cnt_q <= cnt_wr_data;
      else if (strobe) cnt_q <= cnt_q + CNT_ONE;
      if (wrap) begin
        ovf_flag <= 1'b1;
        buf_q    <= data_nxt;
      end else if (ovf_clr) begin
        ovf_flag <= 1'b0;
      end
    end
endmodule

module serial_shift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        src_sel,
  input logic              wr_data_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              cnt_wr_en,
  input logic              ovf_clr,
  input logic [DATA_W-1:0] data_q,
  input logic [DATA_W-1:0] buf_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              ovf_flag,
  input logic              ser_dout
);
  a_r2_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_en |=> data_q == $past(wr_data));

  a_r3_shift_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_data_en |=> (data_q == $past(data_q)) ||
                    (data_q[DATA_W-1:1] == $past(data_q[DATA_W-2:0])));

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr_en |=> (CNT_W'(cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r8_buf_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(buf_q) |-> ovf_flag);

  a_r10_internal_out: assert property (@(posedge clk) disable iff (!rst_n)
    !src_sel[1] |-> ser_dout == data_q[DATA_W-1]);
endmodule

bind serial_shift_unit serial_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .wr_data_en(wr_data_en),
  .wr_data(wr_data), .cnt_wr_en(cnt_wr_en), .ovf_clr(ovf_clr), .data_q(data_q),
  .buf_q(buf_q), .cnt_q(cnt_q), .ovf_flag(ovf_flag), .ser_dout(ser_dout)
);

// File: tb/serial_shift_unit_tb_top.sv
`timescale 1ns/1ps
module serial_shift_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] src_sel = 2'd0;
  logic sw_strobe = 0, timer_match = 0, ser_clk_in = 0, ser_din = 0;
  logic wr_data_en = 0, cnt_wr_en = 0, ovf_clr = 0, ovf_ie = 0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] cnt_wr_data = 4'h0;
  logic [7:0] data_q, buf_q;
  logic [3:0] cnt_q;
  logic ovf_flag, irq, ser_dout;

  always #10 clk = ~clk;

  serial_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .sw_strobe(sw_strobe),
    .timer_match(timer_match), .ser_clk_in(ser_clk_in), .ser_din(ser_din),
    .wr_data_en(wr_data_en), .wr_data(wr_data), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .ovf_clr(ovf_clr), .ovf_ie(ovf_ie),
    .data_q(data_q), .buf_q(buf_q), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
    .irq(irq), .ser_dout(ser_dout)
  );

  int tests = 0, fails = 0;
  string cur_req = "R1";

  int m_data = 0, m_buf = 0, m_cnt = 0, m_ovf = 0, m_hold = 0;
  bit hist[$] = '{0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = 0; m_buf = 0; m_cnt = 0; m_ovf = 0; m_hold = 0;
      hist = '{0, 0, 0};
    end else begin
      int stb, nd, wrapped;
      case (src_sel)
        2'd0: stb = sw_strobe;
        2'd1: stb = timer_match;
        2'd2: stb = (hist[1] && !hist[2]) ? 1 : 0;
        default: stb = (!hist[1] && hist[2]) ? 1 : 0;
      endcase
      if (src_sel < 2 || hist[1] == src_sel[0]) m_hold = (m_data >> 7) & 1;
      if (wr_data_en) nd = wr_data;
      else if (stb != 0) nd = ((m_data * 2) + ser_din) % 256;
      else nd = m_data;
      wrapped = (stb != 0 && !cnt_wr_en && m_cnt == 15) ? 1 : 0;
      if (cnt_wr_en) m_cnt = cnt_wr_data;
      else if (stb != 0) m_cnt = (m_cnt + 1) % 16;
      if (wrapped != 0) begin m_ovf = 1; m_buf = nd; end
      else if (ovf_clr) m_ovf = 0;
      m_data = nd;
      hist.push_front(ser_clk_in);
      void'(hist.pop_back());
    end
  end

  task automatic compare();
    int e_out, e_irq;
    e_out = (src_sel < 2 || hist[1] == src_sel[0]) ? ((m_data >> 7) & 1) : m_hold;
    e_irq = (m_ovf != 0 && ovf_ie) ? 1 : 0;
    tests++;
    if (data_q !== 8'(m_data) || buf_q !== 8'(m_buf) || cnt_q !== 4'(m_cnt) ||
        ovf_flag !== 1'(m_ovf) || irq !== 1'(e_irq) || ser_dout !== 1'(e_out)) begin
      fails++;
      $display("FAIL %s: got data=%h buf=%h cnt=%h ovf=%b irq=%b dout=%b exp data=%h buf=%h cnt=%h ovf=%0d irq=%0d dout=%0d",
               cur_req, data_q, buf_q, cnt_q, ovf_flag, irq, ser_dout,
               m_data, m_buf, m_cnt, m_ovf, e_irq, e_out);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic pulse_sw(input logic din);
    ser_din = din; sw_strobe = 1; cyc(); sw_strobe = 0;
  endtask

  task automatic ext_run(input logic [1:0] mode, input int toggles);
    src_sel = mode;
    for (int i = 0; i < toggles; i++) begin
      ser_din = 1'($urandom);
      ser_clk_in = ~ser_clk_in;
      repeat (2 + ($urandom % 4)) cyc();
      if ((i % 7) == 3) begin wr_data_en = 1; wr_data = 8'($urandom); cyc(); wr_data_en = 0; end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    cyc(); cyc();

    cur_req = "R2";
    wr_data_en = 1; wr_data = 8'hA5; cyc();
    wr_data = 8'h3C; cyc();
    wr_data_en = 0; cyc();

    cur_req = "R10";
    wr_data_en = 1; wr_data = 8'h80; cyc();
    wr_data = 8'h01; cyc();
    wr_data_en = 0; src_sel = 2'd1; cyc();

    cur_req = "R3";
    src_sel = 2'd0;
    for (int i = 0; i < 10; i++) begin
      pulse_sw(1'($urandom));
      timer_match = 1; ser_clk_in = ~ser_clk_in; cyc(); timer_match = 0;
      cyc(); cyc();
    end

    cur_req = "R4";
    wr_data_en = 1; wr_data = 8'h5A; ser_din = 1; sw_strobe = 1; cyc();
    wr_data_en = 0; sw_strobe = 0; cyc();

    cur_req = "R5";
    src_sel = 2'd1;
    for (int i = 0; i < 8; i++) begin
      ser_din = 1'(i); timer_match = 1; cyc(); timer_match = 0;
      sw_strobe = 1; cyc(); sw_strobe = 0;
    end
    ext_run(2'd2, 30);
    cur_req = "R11";
    ext_run(2'd3, 30);
    ext_run(2'd2, 30);

    cur_req = "R6";
    src_sel = 2'd0;
    cnt_wr_en = 1; cnt_wr_data = 4'h7; cyc();
    cnt_wr_data = 4'h3; sw_strobe = 1; cyc();
    cnt_wr_en = 0; sw_strobe = 0; cyc();
    pulse_sw(1); cyc();

    cur_req = "R7";
    cnt_wr_en = 1; cnt_wr_data = 4'hF; cyc(); cnt_wr_en = 0;
    pulse_sw(0); cyc();
    ovf_clr = 1; cyc(); ovf_clr = 0; cyc();
    cnt_wr_en = 1; cnt_wr_data = 4'hF; cyc(); cnt_wr_en = 0;
    ovf_clr = 1; sw_strobe = 1; cyc(); ovf_clr = 0; sw_strobe = 0; cyc();

    cur_req = "R9";
    ovf_ie = 1; cyc(); ovf_clr = 1; cyc(); ovf_clr = 0; cyc();

    cur_req = "R12";
    cnt_wr_en = 1; cnt_wr_data = 4'hF; cyc(); cnt_wr_en = 0;
    src_sel = 2'd3; ser_clk_in = 1; repeat (5) cyc();
    ser_clk_in = 0; repeat (5) cyc();

    cur_req = "R8";
    src_sel = 2'd0; ovf_clr = 1; cyc(); ovf_clr = 0;
    for (int i = 0; i < 40; i++) pulse_sw(1'($urandom));

    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      if ((i % 250) == 0) src_sel = 2'($urandom);
      sw_strobe   = ($urandom % 4) == 0;
      timer_match = ($urandom % 4) == 0;
      if (($urandom % 3) == 0) ser_clk_in = ~ser_clk_in;
      ser_din     = 1'($urandom);
      wr_data_en  = ($urandom % 13) == 0;
      wr_data     = 8'($urandom);
      cnt_wr_en   = ($urandom % 17) == 0;
      cnt_wr_data = 4'($urandom);
      ovf_clr     = ($urandom % 9) == 0;
      ovf_ie      = 1'($urandom);
      cyc();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule